// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from a set of separate request lines and one unmaskable line. It presents the processor with a single interrupt signal. On acknowledge, it returns the reserved vector address of the request that won. Each maskable line is gated by its own enable bit and by one global enable. Among the lines that pass, the lowest index has the highest priority. The unmaskable line outranks every maskable line and ignores every enable bit.

Requests are detected on rising edges after a synchroniser and are held until the winning line is acknowledged. On acknowledge, the winner moves from pending to in service. Service nests by level: while a level is in service, only strictly higher levels may raise the interrupt. The processor closes the most urgent open service by pulsing an end-of-service strobe. Handler fetch and register saving are left to the processor.

Top module: `prio_vec_intc`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it goes high, `int_o` and `vec_o` read 0 and all pending and in-service state clears. After reset is released, a request must produce a new rising edge before it raises `int_o`.
- R2: A line's request is latched on a rising edge of its input. Holding the input high after that line has been acknowledged does not latch it again.
- R3: A maskable line whose bit in `line_en_i` is 0 does not raise `int_o`, but its latched request is kept. Setting the bit later raises `int_o` on the next clock edge.
- R4: While `glob_en_i` is 0, no maskable line raises `int_o`. Latched requests are kept, and raising `glob_en_i` raises `int_o` on the next clock edge.
- R5: Among eligible maskable requests, the lowest index wins. On acknowledge, `vec_o` becomes `VEC_BASE + 4*index` on the ack clock edge.
- R6: Acknowledge clears the winner's latched request and records the winner as in service. With nothing else eligible, `int_o` is low one clock edge after the ack edge.
- R7: While line k is in service, requests on lines with index k or higher do not raise `int_o`. Requests on lower indices do raise it.
- R8: A `eoi_i` pulse ends the most urgent open service: the unmaskable one first, then the lowest line index. Requests that this service was holding off then become eligible.
- R9: A rising edge on `nmi_i` raises `int_o` whatever `glob_en_i`, `line_en_i` or the maskable in-service state is. It wins over every maskable request, and on acknowledge `vec_o` becomes `NMI_VEC`. While it is in service, all maskable lines are held off.
- R10: An acknowledge that arrives while no request is eligible changes nothing: `vec_o` keeps its value and no pending or in-service state moves.
- R11: `int_o` is a register. It rises on the fourth clock edge after a request input rises: two synchroniser stages, one edge-capture stage, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | N_LINES | Maskable request lines, index 0 most urgent |
| nmi_i | input | 1 | Unmaskable request, rising-edge detected |
| line_en_i | input | N_LINES | Per-line enable bits |
| glob_en_i | input | 1 | Global enable for all maskable lines |
| ack_i | input | 1 | Acknowledge strobe from the processor |
| eoi_i | input | 1 | End-of-service strobe |
| int_o | output | 1 | Registered interrupt request to the processor |
| vec_o | output | ADDR_W | Vector address of the last accepted acknowledge |

## Verification
The bench builds the block with its defaults: eight lines, two synchroniser stages, a 16-bit vector, line base 0x0040 and unmaskable vector 0x0008. With only eight lines, the bench can visit every single line and every ordered pair of lines. For each pair it checks the winner, that the loser is held off by the winner's service, that a repeat acknowledge is ignored, and that the loser is released after end-of-service. Nesting, masking, the unmaskable line against every enable, and the exact latency of the interrupt output are covered by directed sequences. Every expected vector is computed from the base plus four times the index.

// File: rtl/prio_vec_intc_pkg.sv
package prio_vec_intc_pkg;

  // Address of a reserved handler slot: base plus one word per slot.
  function automatic logic [31:0] slot_addr(input logic [31:0] base,
                                            input logic [31:0] slot);
    return base + (slot << 2);
  endfunction

endpackage

// File: rtl/vic_edge_rise.sv
module vic_edge_rise #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/vic_lowest_pick.sv
module vic_lowest_pick #(
  parameter int W     = 9,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     req,
  output logic [W-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int                N_LINES     = 8,
  parameter int                ADDR_W      = 16,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] VEC_BASE    = 'h0040,
  parameter logic [ADDR_W-1:0] NMI_VEC     = 'h0008
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               nmi_i,
  input  logic [N_LINES-1:0] line_en_i,
  input  logic               glob_en_i,
  input  logic               ack_i,
  input  logic               eoi_i,
  output logic               int_o,
  output logic [ADDR_W-1:0]  vec_o
);
  import prio_vec_intc_pkg::*;

  // Slot 0 is the unmaskable source; slot g+1 is request line g.
  localparam int SLOTS = N_LINES + 1;
  localparam int IDX_W = $clog2(SLOTS);

  logic [SLOTS-1:0] raw_in, rise_v, pend_q, isr_q, elig, cand;
  logic [SLOTS-1:0] grant, clr_v, set_v, eoi_clr;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_any, ack_take;
  logic [ADDR_W-1:0] vec_calc;

  assign raw_in = {irq_i, nmi_i};

  for (genvar g = 0; g < SLOTS; g++) begin : g_src
    vic_edge_rise #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst    (rst),
      .din    (raw_in[g]),
      .rise_o (rise_v[g])
    );
    if (g == 0) begin : g_nmi
      assign elig[g] = ~isr_q[0];
    end else begin : g_line
      // Held off by any open service at this level or above.
      assign elig[g] = line_en_i[g-1] & glob_en_i & ~(|isr_q[g:0]);
    end
  end

  assign cand = pend_q & elig;

  vic_lowest_pick #(.W(SLOTS)) u_pick (
    .req   (cand),
    .grant (grant),
    .idx   (pick_idx),
    .any   (pick_any)
  );

  assign ack_take = ack_i & pick_any;
  assign clr_v    = ack_take ? grant : '0;
  assign set_v    = ack_take ? grant : '0;
  assign eoi_clr  = eoi_i ? (isr_q & (~isr_q + SLOTS'(1))) : '0;

  assign vec_calc = (pick_idx == '0) ? NMI_VEC
                  : ADDR_W'(slot_addr(32'(VEC_BASE), 32'(pick_idx) - 32'd1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      isr_q  <= '0;
      int_o  <= 1'b0;
      vec_o  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_v) | rise_v;
      isr_q  <= (isr_q & ~eoi_clr) | set_v;
      int_o  <= pick_any;
      if (ack_take) vec_o <= vec_calc;
    end
  end

  // Checks next to the logic they guard.
  assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_nmi_first_R9: assert property (@(posedge clk) disable iff (rst)
    cand[0] |-> grant[0]);

  assert_nest_order_R7: assert property (@(posedge clk) disable iff (rst)
    ack_take |-> (isr_q == '0 || grant < (isr_q & (~isr_q + SLOTS'(1)))));

  assert_ack_records_R6: assert property (@(posedge clk) disable iff (rst)
    ack_take |=> (isr_q & $past(grant)) != '0);

  assert_eoi_pops_one_R8: assert property (@(posedge clk) disable iff (rst)
    (eoi_i && !ack_take && isr_q != '0) |=>
      ($countones(isr_q) + 1 == $countones($past(isr_q))));

  assert_idle_ack_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !pick_any) |=> $stable(vec_o) && $stable(isr_q));
endmodule

// File: tb/prio_vec_intc_tb.sv
`timescale 1ns/1ps
module prio_vec_intc_tb;
  localparam int N = 8;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h0040;
  localparam logic [AW-1:0] NVEC = 16'h0008;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq = '0;
  logic          nmi = 1'b0;
  logic [N-1:0]  en  = '1;
  logic          gen = 1'b1;
  logic          ack = 1'b0;
  logic          eoi = 1'b0;
  logic          int_w;
  logic [AW-1:0] vec_w;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_vec_intc #(.N_LINES(N), .ADDR_W(AW), .SYNC_STAGES(2),
                  .VEC_BASE(BASE), .NMI_VEC(NVEC)) u_dut (
    .clk(clk), .rst(rst), .irq_i(irq), .nmi_i(nmi), .line_en_i(en),
    .glob_en_i(gen), .ack_i(ack), .eoi_i(eoi), .int_o(int_w), .vec_o(vec_w)
  );

  function automatic logic [AW-1:0] exp_vec(input int i);
    return BASE + AW'(4 * i);
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic raise(input int i);
    irq[i] = 1'b1; step(5); irq[i] = 1'b0; step(1);
  endtask

  task automatic raise_nmi();
    nmi = 1'b1; step(5); nmi = 1'b0; step(1);
  endtask

  task automatic do_ack();
    ack = 1'b1; step(1); ack = 1'b0; step(1);
  endtask

  task automatic do_eoi();
    eoi = 1'b1; step(1); eoi = 1'b0; step(1);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1 int", 32'(int_w), 0);
    chk("R1 vec", 32'(vec_w), 0);
    rst = 1'b0;
    step(1);

    // R11 latency: four edges from the input rise to int_o.
    irq[3] = 1'b1; step(3);
    chk("R11 int before 4th edge", 32'(int_w), 0);
    step(1);
    chk("R11 int at 4th edge", 32'(int_w), 1);
    irq[3] = 1'b0; step(1);
    do_ack();
    chk("R5 vec line3", 32'(vec_w), 32'(exp_vec(3)));
    chk("R6 int low after ack", 32'(int_w), 0);
    do_eoi();

    // R2: a held level does not re-latch.
    irq[2] = 1'b1; step(5);
    chk("R2 int", 32'(int_w), 1);
    do_ack();
    chk("R2 vec", 32'(vec_w), 32'(exp_vec(2)));
    do_eoi(); step(3);
    chk("R2 no relatch", 32'(int_w), 0);
    irq[2] = 1'b0; step(4);

    // R5 single-line sweep.
    for (int i = 0; i < N; i++) begin
      raise(i);
      chk("R5 sweep int", 32'(int_w), 1);
      do_ack();
      chk("R5 sweep vec", 32'(vec_w), 32'(exp_vec(i)));
      chk("R6 sweep int low", 32'(int_w), 0);
      do_eoi();
    end

    // Pair sweep: R5 priority, R7 hold-off, R10 idle ack, R8 release.
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        irq[i] = 1'b1; irq[j] = 1'b1; step(5);
        irq[i] = 1'b0; irq[j] = 1'b0; step(1);
        do_ack();
        chk("R5 pair winner", 32'(vec_w), 32'(exp_vec(i)));
        chk("R7 pair loser held", 32'(int_w), 0);
        do_ack();
        chk("R10 idle ack vec held", 32'(vec_w), 32'(exp_vec(i)));
        do_eoi();
        chk("R8 pair loser released", 32'(int_w), 1);
        do_ack();
        chk("R5 pair loser vec", 32'(vec_w), 32'(exp_vec(j)));
        do_eoi();
      end
    end

    // Nesting: R7 and R8.
    raise(5); do_ack();
    chk("R5 nest outer", 32'(vec_w), 32'(exp_vec(5)));
    raise(2);
    chk("R7 higher interrupts", 32'(int_w), 1);
    do_ack();
    chk("R7 nested vec", 32'(vec_w), 32'(exp_vec(2)));
    raise(6);
    chk("R7 lower held", 32'(int_w), 0);
    do_eoi();
    chk("R8 still held by outer", 32'(int_w), 0);
    do_eoi();
    chk("R8 released after outer", 32'(int_w), 1);
    do_ack();
    chk("R8 released vec", 32'(vec_w), 32'(exp_vec(6)));
    do_eoi();

    // R3 per-line enable.
    en[4] = 1'b0; raise(4);
    chk("R3 disabled silent", 32'(int_w), 0);
    do_ack();
    chk("R10 ack ignored vec", 32'(vec_w), 32'(exp_vec(6)));
    en[4] = 1'b1; step(1);
    chk("R3 pending kept", 32'(int_w), 1);
    do_ack();
    chk("R3 vec", 32'(vec_w), 32'(exp_vec(4)));
    do_eoi();

    // R4 global enable.
    gen = 1'b0; raise(1);
    chk("R4 global off", 32'(int_w), 0);
    gen = 1'b1; step(1);
    chk("R4 global on", 32'(int_w), 1);
    do_ack();
    chk("R4 vec", 32'(vec_w), 32'(exp_vec(1)));
    do_eoi();

    // R9 unmaskable line over enables and maskable service.
    raise(7); do_ack();
    gen = 1'b0; en = '0;
    raise(0);
    chk("R9 masked line silent", 32'(int_w), 0);
    raise_nmi();
    chk("R9 nmi int", 32'(int_w), 1);
    do_ack();
    chk("R9 nmi vec", 32'(vec_w), 32'(NVEC));
    chk("R9 nmi service holds all", 32'(int_w), 0);
    do_eoi();
    gen = 1'b1; en = '1; step(1);
    chk("R8 nmi closed first", 32'(int_w), 1);
    do_ack();
    chk("R8 line0 vec", 32'(vec_w), 32'(exp_vec(0)));
    do_eoi(); do_eoi();
    chk("R8 all closed", 32'(int_w), 0);

    // R9 simultaneous with line 0.
    irq[0] = 1'b1; nmi = 1'b1; step(5);
    irq[0] = 1'b0; nmi = 1'b0; step(1);
    do_ack();
    chk("R9 nmi wins", 32'(vec_w), 32'(NVEC));
    chk("R9 line0 held", 32'(int_w), 0);
    do_eoi();
    chk("R9 line0 after", 32'(int_w), 1);
    do_ack();
    chk("R9 line0 vec", 32'(vec_w), 32'(exp_vec(0)));
    do_eoi();

    // R1 reset mid-run clears pending.
    raise(6);
    chk("R1 pre int", 32'(int_w), 1);
    rst = 1'b1; step(1);
    chk("R1 mid int", 32'(int_w), 0);
    chk("R1 mid vec", 32'(vec_w), 0);
    rst = 1'b0; step(6);
    chk("R1 pending cleared", 32'(int_w), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule